// File: doc/BRIEF.md
# PCI Clock-Run Power Controller

This block is the host end of a shared, active-low, open-drain clock-run handshake on a PCI-style bus. It decides when the bus clock may be stopped and when it must come back. While the bus has work, the controller pulls the clock-run line low. When all activity has ceased, it lets the line float high. It then watches the line through a synchronizer, and if no peer pulls the line low for a short window, it asks the external clock synthesizer to stop the bus clock by driving `stop_req_n` low.

A peer that needs the clock pulls the shared line low while the clock is stopped. The controller sees this, joins in driving the line low, and withdraws its stop request shortly afterwards. Several kinds of internal activity hold the line low for as long as they last: bus requests, a serial-interrupt frame or continuous serial-interrupt mode, DMA or bus-master requests, cycles waiting from the upstream hub, and bus cycles in flight. An internal wake request and a software enable do the same. All logic runs on a free-running clock, and the pins carry no data stream, so every port is a plain level signal.

The sequencer has four states: running, released-wait, stopped and restarting. After reset it starts in running. The window begins when the line is released. It consists of SYNC_STAGES settling cycles, in which the line is not judged because the synchronizer still holds the controller's own pull, followed by WAIT_CYC cycles in which the line is judged.

Top module: `pci_clkrun_ctrl`

## Requirements
- R1: After reset, `clkrun_oe` is 1 (line pulled low) and `stop_req_n` is 1 (no stop requested).
- R2: If any bit of `bus_req_n` is 0, or any of `dma_req`, `irq_frame_busy`, `irq_cont_mode`, `hub_cycle_pend`, `bus_cycle_busy` is 1, then from the next edge `clkrun_oe` is 1 and `stop_req_n` is 1, in every state.
- R3: While `enable` is 0, from the next edge `clkrun_oe` is 1 and `stop_req_n` is 1. The clock is never stopped.
- R4: In the running state, with `enable` at 1 and no activity and no wake request, `clkrun_oe` falls at the next edge. That edge starts the release window.
- R5: If the line is observed high in every judged cycle, `stop_req_n` falls exactly SYNC_STAGES+WAIT_CYC edges after `clkrun_oe` fell. With the default parameters, that is 5 edges.
- R6: A peer pull of the line reaches the sequencer SYNC_STAGES edges after it is first sampled. If it arrives during the judged part of the window, `clkrun_oe` returns to 1 at the next edge and the stop is cancelled. A pull starting in window cycle c (c = 0..2 with defaults) raises `clkrun_oe` at edge c+3.
- R7: A peer pull seen while stopped, even a pull lasting one cycle, sets `clkrun_oe` to 1 at the edge after it is observed. `stop_req_n` rises one edge later, which is within 4 edges of the first sample.
- R8: A wake request while stopped sets `clkrun_oe` to 1 and `stop_req_n` to 1 on the same edge.
- R9: In the restarting state, `stop_req_n` is still 0 while `clkrun_oe` is 1. This state lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Software enable for clock stopping |
| wake_req | input | 1 | Internal request for the bus clock |
| bus_req_n | input | NREQ | Active-low bus request lines |
| dma_req | input | 1 | Pending DMA or bus-master request |
| irq_frame_busy | input | 1 | Serial-interrupt frame in progress |
| irq_cont_mode | input | 1 | Serial-interrupt logic in continuous mode |
| hub_cycle_pend | input | 1 | Cycle from the upstream hub waiting for the bus |
| bus_cycle_busy | input | 1 | Bus cycle in flight, including a delayed transaction |
| clkrun_in | input | 1 | Resolved level of the shared clock-run line |
| clkrun_oe | output | 1 | 1 = pull the clock-run line low |
| stop_req_n | output | 1 | Active-low request to stop the bus clock |

## Verification
The assertions assume that `clkrun_in` is the wired-low result of `clkrun_oe` and the peers' pulls, so the line is low whenever the controller drives it. The bench resolves the line that way from a peer model. The assertions also assume that activity inputs change only between clock edges. The stimulus sets them shortly after a rising edge. Peer pulls are applied as one-cycle pulses at each offset of the window and of the stopped state, so every path through the synchronizer is exercised.

// File: rtl/crun_pkg.sv
package crun_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAIT    = 2'd1,
    ST_STOP    = 2'd2,
    ST_RESTART = 2'd3
  } crun_state_e;
endpackage

// File: rtl/crun_sync.sv
module crun_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/crun_activity_merge.sv
module crun_activity_merge #(
  parameter int NREQ = 2
) (
  input  logic [NREQ-1:0] bus_req_n,
  input  logic            dma_req,
  input  logic            irq_frame_busy,
  input  logic            irq_cont_mode,
  input  logic            hub_cycle_pend,
  input  logic            bus_cycle_busy,
  output logic            hold_active
);
  logic [NREQ-1:0] req_seen;

  generate
    for (genvar i = 0; i < NREQ; i++) begin : g_req
      assign req_seen[i] = ~bus_req_n[i];
    end
  endgenerate

  assign hold_active = (|req_seen) | dma_req | irq_frame_busy | irq_cont_mode
                     | hub_cycle_pend | bus_cycle_busy;
endmodule

// File: rtl/crun_seq_fsm.sv
module crun_seq_fsm
  import crun_pkg::*;
#(
  parameter int SETTLE   = 2,
  parameter int WAIT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic wake_req,
  input  logic hold_active,
  input  logic line_hi,
  output logic clkrun_oe,
  output logic stop_req_n
);
  localparam int LAST = SETTLE + WAIT_CYC - 1;
  localparam int CW   = $clog2(LAST + 2);
  localparam int RW   = $clog2(LAST + 3);

  crun_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic busy;
  logic judged;

  assign busy   = hold_active | wake_req | ~enable;
  assign judged = (cnt_q >= CW'(SETTLE));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_RUN: begin
        if (!busy) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end
      end
      ST_WAIT: begin
        if (busy)                  st_d = ST_RUN;
        else if (judged && !line_hi) st_d = ST_RUN;
        else if (cnt_q == CW'(LAST)) st_d = ST_STOP;
        else                         cnt_d = cnt_q + 1'b1;
      end
      ST_STOP: begin
        if (busy)          st_d = ST_RUN;
        else if (!line_hi) st_d = ST_RESTART;
      end
      ST_RESTART: st_d = ST_RUN;
      default:    st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign clkrun_oe  = (st_q == ST_RUN) || (st_q == ST_RESTART);
  assign stop_req_n = !((st_q == ST_STOP) || (st_q == ST_RESTART));

  // Independent run-length of released cycles, used only by the checks below.
  logic [RW-1:0] rel_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rel_run_q <= '0;
    else if (clkrun_oe)                  rel_run_q <= '0;
    else if (rel_run_q != RW'(LAST + 2)) rel_run_q <= rel_run_q + 1'b1;
  end

  a_r2_hold_drives_line: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |=> (clkrun_oe && stop_req_n));

  a_r3_disable_keeps_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (clkrun_oe && stop_req_n));

  a_r4_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !busy) |=> !clkrun_oe);

  a_r5_stop_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_req_n) |-> (rel_run_q == RW'(LAST + 1)));

  a_r6_peer_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && judged && !line_hi) |=> (clkrun_oe && stop_req_n));

  a_r7_peer_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP && !line_hi) |=> clkrun_oe ##1 stop_req_n);

  a_r8_wake_together: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_req_n && !clkrun_oe && wake_req) |=> (clkrun_oe && stop_req_n));

  a_r9_restart_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_req_n && clkrun_oe) |=> stop_req_n);
endmodule

// File: rtl/pci_clkrun_ctrl.sv
module pci_clkrun_ctrl #(
  parameter int NREQ        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_CYC    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            wake_req,
  input  logic [NREQ-1:0] bus_req_n,
  input  logic            dma_req,
  input  logic            irq_frame_busy,
  input  logic            irq_cont_mode,
  input  logic            hub_cycle_pend,
  input  logic            bus_cycle_busy,
  input  logic            clkrun_in,
  output logic            clkrun_oe,
  output logic            stop_req_n
);
  logic line_hi;
  logic hold_active;

  crun_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (clkrun_in),
    .q_out (line_hi)
  );

  crun_activity_merge #(.NREQ(NREQ)) u_merge (
    .bus_req_n      (bus_req_n),
    .dma_req        (dma_req),
    .irq_frame_busy (irq_frame_busy),
    .irq_cont_mode  (irq_cont_mode),
    .hub_cycle_pend (hub_cycle_pend),
    .bus_cycle_busy (bus_cycle_busy),
    .hold_active    (hold_active)
  );

  crun_seq_fsm #(.SETTLE(SYNC_STAGES), .WAIT_CYC(WAIT_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .wake_req    (wake_req),
    .hold_active (hold_active),
    .line_hi     (line_hi),
    .clkrun_oe   (clkrun_oe),
    .stop_req_n  (stop_req_n)
  );

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (clkrun_oe && stop_req_n));
endmodule

// File: tb/pci_clkrun_ctrl_tb_top.sv
module pci_clkrun_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic wake_req = 1'b0;
  logic [1:0] bus_req_n = 2'b11;
  logic dma_req = 1'b0, irq_frame_busy = 1'b0, irq_cont_mode = 1'b0;
  logic hub_cycle_pend = 1'b0, bus_cycle_busy = 1'b0;
  logic peer_pull = 1'b0;
  logic clkrun_oe, stop_req_n, clkrun_line;
  int   n_checks = 0, n_errors = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  assign clkrun_line = !(clkrun_oe || peer_pull);

  pci_clkrun_ctrl #(.NREQ(2), .SYNC_STAGES(2), .WAIT_CYC(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wake_req(wake_req),
    .bus_req_n(bus_req_n), .dma_req(dma_req), .irq_frame_busy(irq_frame_busy),
    .irq_cont_mode(irq_cont_mode), .hub_cycle_pend(hub_cycle_pend),
    .bus_cycle_busy(bus_cycle_busy), .clkrun_in(clkrun_line),
    .clkrun_oe(clkrun_oe), .stop_req_n(stop_req_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic exp_oe, input logic exp_st, input string req);
    n_checks++;
    if (clkrun_oe !== exp_oe || stop_req_n !== exp_st) begin
      n_errors++;
      $display("FAIL %s: oe=%b stop_n=%b expected oe=%b stop_n=%b",
               req, clkrun_oe, stop_req_n, exp_oe, exp_st);
    end
  endtask

  // kinds 0..6: activity sources (R2), 7: enable low (R3), 8: wake (R8)
  task automatic set_kind(input int k, input logic on);
    case (k)
      0: bus_req_n[0] = !on;
      1: bus_req_n[1] = !on;
      2: dma_req = on;
      3: irq_frame_busy = on;
      4: irq_cont_mode = on;
      5: hub_cycle_pend = on;
      6: bus_cycle_busy = on;
      7: enable = !on;
      default: wake_req = on;
    endcase
  endtask

  task automatic park();
    enable = 1'b0;
    peer_pull = 1'b0;
    repeat (4) tick();
  endtask

  // Edge e0: enters the release window (R4).
  task automatic open_window();
    enable = 1'b1;
    tick();
    check(1'b0, 1'b1, "R4");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    check(1'b1, 1'b1, "R1");
    tick();
    check(1'b1, 1'b1, "R1");
    park();
    check(1'b1, 1'b1, "R3");

    // R5: full window trajectory with the line left high.
    open_window();
    for (int n = 1; n <= 5; n++) begin
      tick();
      check(1'b0, (n < 5), "R5");
    end
    park();

    // Sweep of every hold kind over every window cycle and the stopped state.
    for (int k = 0; k < 9; k++) begin
      for (int p = 0; p <= 5; p++) begin
        open_window();
        repeat (p) tick();
        if (p == 5) check(1'b0, 1'b0, "R5");
        set_kind(k, 1'b1);
        tick();
        if (k == 8)      check(1'b1, 1'b1, "R8");
        else if (k == 7) check(1'b1, 1'b1, "R3");
        else             check(1'b1, 1'b1, "R2");
        tick();
        check(1'b1, 1'b1, (k == 7) ? "R3" : ((k == 8) ? "R8" : "R2"));
        set_kind(k, 1'b0);
        park();
      end
    end

    // One-cycle peer pulses at window cycle c (0..4) and in the stopped state (5).
    for (int c = 0; c <= 5; c++) begin
      open_window();
      repeat (c) tick();
      peer_pull = 1'b1;
      for (int n = c + 1; n <= c + 4; n++) begin
        tick();
        peer_pull = 1'b0;
        check((n == c + 3) || (c >= 3 && n == c + 4),
              !(c >= 3 && n >= 5 && n <= c + 3),
              (c >= 3) ? ((n == c + 3) ? "R9" : "R7") : "R6");
      end
      park();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule